// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This block is a watchdog timer driven through one write-only control register on a 32-bit register bus. A control word carries a 9-bit count, an enable command and a 7-bit key. While the watchdog is enabled, software may only rewrite the control register by presenting the bitwise complement of the key it stored last, so every restart must alternate the key. When the key check passes, the write loads the counter, clears any pending non-maskable interrupt, and starts or stops the count.

The counter decrements on a slow tick-enable input. Expiry happens in two stages. The first expiry raises the NMI and reloads a short grace count. If the grace count also expires with no accepted write in between, the block asserts a system reset request. That request stays asserted until the block itself is reset. A status register reports three flags: whether the counter is running, whether the NMI is pending, and whether reset has been requested.

The controller is a four-state machine. IDLE means stopped. ARMED means counting the main interval. GRACE means the NMI is pending while the grace count runs. TRIPPED means reset has been requested. The transitions are:
- accept-enable moves any state except TRIPPED to ARMED.
- accept-disable moves any state except TRIPPED to IDLE.
- first-expiry moves ARMED to GRACE.
- second-expiry moves GRACE to TRIPPED.
- TRIPPED leaves only through the block reset.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, the status word reads 0, `nmi_o` and `rst_req_o` are low, and the watchdog counts as disabled.
- R2: A write takes effect only when `bus_wr` is high and `bus_addr` equals the control offset 0x40. In the control word, bits [8:0] are the count, bit 8 is also the enable command, and bits [15:9] are the key. Writes to any other offset have no effect.
- R3: While the watchdog is disabled, a control write is accepted whatever its key holds.
- R4: While the watchdog is enabled, a control write is accepted only if its key equals the 7-bit complement of the stored key. Any other write is ignored entirely: state, counter and stored key all keep their values.
- R5: An accepted write loads the counter from the count field and clears the NMI. With enable set the counter runs; with enable clear it stops and never expires.
- R6: While running, the counter decrements once per cycle in which `tick_en` is high. An expiry happens on a tick that finds the counter at 0, so a loaded count N expires on the (N+1)th tick.
- R7: At the first expiry, `nmi_o` rises on that same clock edge, the counter reloads the grace count GRACE (default 10), and counting continues.
- R8: If the grace count expires with no accepted write, `rst_req_o` rises and the counter stops. `rst_req_o` and `nmi_o` then stay high and every write is ignored until `rst_n` is asserted.
- R9: An accepted write made during the grace stage lowers `nmi_o` and returns the block to the state chosen by its enable bit.
- R10: With `bus_addr` at the status offset 0x44, `bus_rdata` bit 0 shows running, bit 1 shows NMI pending and bit 2 shows reset requested, with all other bits 0. At any other address `bus_rdata` is 0.
- R11: When an accepted write and a tick fall in the same cycle, the write wins: the counter takes the written count and does not decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset, used for both write and read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Status read data |
| tick_en | input | 1 | Slow decrement tick, high for one cycle per tick |
| nmi_o | output | 1 | Non-maskable interrupt, first-stage expiry |
| rst_req_o | output | 1 | System reset request, second-stage expiry |

## Verification
A wrong stored key shows up on the next control write. A write that should pass is dropped, or one that should be rejected gets through, and the running flag in the status word is wrong one cycle later. A wrong counter value stays hidden until expiry, where it moves the rising edge of `nmi_o` or `rst_req_o` by one or more ticks. For that reason the tests count ticks exactly, checking one tick before each expiry and again on the tick of it. A wrong state shows at once in the status flags.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    typedef enum logic [1:0] {
        WD_IDLE    = 2'd0,
        WD_ARMED   = 2'd1,
        WD_GRACE   = 2'd2,
        WD_TRIPPED = 2'd3
    } wd_state_e;
endpackage

// File: rtl/wdg_key_gate.sv
module wdg_key_gate #(
    parameter int KEY_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic             lock,
    input  logic             en_new,
    input  logic [KEY_W-1:0] key_new,
    output logic             accept,
    output logic             en_q
);
    logic [KEY_W-1:0] key_q;

    // The key check applies only once enabled; while disabled any key passes.
    always_comb begin
        accept = wr_hit && !lock && (!en_q || (key_new == ~key_q));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q <= '0;
            en_q  <= 1'b0;
        end else if (accept) begin
            key_q <= key_new;
            en_q  <= en_new;
        end
    end

    // R3: while disabled, a write hit that is not locked must pass.
    p_open_when_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !lock && !en_q) |-> accept);
endmodule

// File: rtl/wdg_down_counter.sv
module wdg_down_counter #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         zero
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (dec)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R6: a decrement moves the count down by exactly one.
    p_dec_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && !zero) |=> (cnt == $past(cnt) - 1'b1));

    // R11: a load takes the loaded value even when a decrement is also requested.
    p_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(load_val)));
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import wdg_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int CNT_W    = 9,
    parameter int KEY_W    = 7,
    parameter int GRACE    = 10,
    parameter int CTRL_OFS = 'h40,
    parameter int STAT_OFS = 'h44
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick_en,
    output logic              nmi_o,
    output logic              rst_req_o
);
    localparam int EN_BIT  = CNT_W - 1;
    localparam int KEY_LSB = CNT_W;
    localparam logic [CNT_W-1:0] GRACE_CNT = CNT_W'(GRACE);

    wd_state_e        state_q, state_d;
    logic             wr_hit, accept, en_q, lock;
    logic             en_new;
    logic [KEY_W-1:0] key_new;
    logic [CNT_W-1:0] cnt_new, cnt, load_val;
    logic             load, dec, zero, running;

    assign wr_hit  = bus_wr && (bus_addr == ADDR_W'(CTRL_OFS));
    assign cnt_new = bus_wdata[CNT_W-1:0];
    assign en_new  = bus_wdata[EN_BIT];
    assign key_new = bus_wdata[KEY_LSB +: KEY_W];
    assign lock    = (state_q == WD_TRIPPED);

    wdg_key_gate #(.KEY_W(KEY_W)) u_key (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (wr_hit),
        .lock    (lock),
        .en_new  (en_new),
        .key_new (key_new),
        .accept  (accept),
        .en_q    (en_q)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= WD_IDLE;
        else
            state_q <= state_d;
    end

    // Next state and counter control
    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        load_val = cnt_new;
        dec      = 1'b0;
        if (accept) begin
            load    = 1'b1;
            state_d = en_new ? WD_ARMED : WD_IDLE;
        end else begin
            unique case (state_q)
                WD_IDLE: ;
                WD_ARMED: begin
                    if (tick_en && zero) begin
                        state_d  = WD_GRACE;
                        load     = 1'b1;
                        load_val = GRACE_CNT;
                    end else if (tick_en) begin
                        dec = 1'b1;
                    end
                end
                WD_GRACE: begin
                    if (tick_en && zero)
                        state_d = WD_TRIPPED;
                    else if (tick_en)
                        dec = 1'b1;
                end
                WD_TRIPPED: ;
                default: state_d = WD_IDLE;
            endcase
        end
    end

    wdg_down_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .dec      (dec),
        .cnt      (cnt),
        .zero     (zero)
    );

    // Outputs
    always_comb begin
        running   = (state_q == WD_ARMED) || (state_q == WD_GRACE);
        nmi_o     = (state_q == WD_GRACE) || (state_q == WD_TRIPPED);
        rst_req_o = (state_q == WD_TRIPPED);
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(STAT_OFS))
            bus_rdata[2:0] = {rst_req_o, nmi_o, running};
    end

    // R4: a rejected write leaves the state and the counter alone.
    p_reject_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !accept && !tick_en) |=> ($stable(state_q) && $stable(cnt)));

    // R7: the first expiry enters grace with the grace count loaded.
    p_expiry_grace_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_ARMED && tick_en && zero && !accept) |=>
            (state_q == WD_GRACE && cnt == GRACE_CNT && nmi_o));

    // R8: the reset request is sticky and always comes after the NMI.
    p_trip_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> rst_req_o);
    p_nmi_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req_o) |-> $past(nmi_o));

    // R9: an accepted write clears the NMI.
    p_accept_clears_nmi_r9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !nmi_o);

    // R5: the enable state held by the key gate agrees with the running flag.
    p_enable_matches_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock) |-> (en_q == running));

    // R10: reads away from the status offset return zero.
    p_rdata_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != ADDR_W'(STAT_OFS)) |-> (bus_rdata == '0));
endmodule

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_en = 1'b0;
    logic        nmi_o, rst_req_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    keyed_watchdog u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tick_en   (tick_en),
        .nmi_o     (nmi_o),
        .rst_req_o (rst_req_o)
    );

    function automatic logic [31:0] mk(input logic [6:0] key, input logic en, input logic [7:0] lo);
        return {16'h0, key, en, lo};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_wr = 1'b0; tick_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] addr, input logic [31:0] data, input logic with_tick = 1'b0);
        bus_wr = 1'b1; bus_addr = addr; bus_wdata = data; tick_en = with_tick;
        @(negedge clk);
        bus_wr = 1'b0; tick_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1;
            @(negedge clk);
            tick_en = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic status(output logic [31:0] s);
        bus_addr = 8'h44;
        #1 s = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] s;
        do_reset();
        status(s);
        chk("R1 status after reset", s, 32'h0);
        chk("R1 nmi after reset", {31'h0, nmi_o}, 32'h0);
        chk("R1 rst_req after reset", {31'h0, rst_req_o}, 32'h0);
    endtask

    task automatic t_disabled();
        logic [31:0] s;
        do_reset();
        wr(8'h40, mk(7'h5A, 1'b0, 8'h05));
        wr(8'h40, mk(7'h11, 1'b0, 8'h02));
        status(s);
        chk("R3 disabled writes accepted, stopped", s, 32'h0);
        ticks(20);
        chk("R5 stopped counter never expires", {31'h0, nmi_o}, 32'h0);
    endtask

    task automatic t_two_stage();
        logic [31:0] s;
        do_reset();
        wr(8'h40, mk(7'h15, 1'b1, 8'h03));
        ticks(259);
        chk("R6 no nmi one tick before expiry", {31'h0, nmi_o}, 32'h0);
        ticks(1);
        chk("R7 nmi on expiry tick", {31'h0, nmi_o}, 32'h1);
        status(s);
        chk("R10 status running+nmi", s, 32'h3);
        ticks(10);
        chk("R8 no reset before grace ends", {31'h0, rst_req_o}, 32'h0);
        ticks(1);
        chk("R8 reset request on grace expiry", {31'h0, rst_req_o}, 32'h1);
        wr(8'h40, mk(7'h6A, 1'b0, 8'h00));
        ticks(3);
        status(s);
        chk("R8 sticky trip, write ignored", s, 32'h6);
        bus_addr = 8'h48;
        #1 chk("R10 other address reads zero", bus_rdata, 32'h0);
    endtask

    task automatic t_bad_key();
        logic [31:0] s;
        do_reset();
        wr(8'h40, mk(7'h15, 1'b1, 8'h00));
        ticks(100);
        wr(8'h40, mk(7'h33, 1'b0, 8'h00));
        status(s);
        chk("R4 wrong key ignored", s, 32'h1);
        ticks(156);
        chk("R4 counter untouched by rejected write", {31'h0, nmi_o}, 32'h0);
        ticks(1);
        chk("R4 expiry timing kept", {31'h0, nmi_o}, 32'h1);
    endtask

    task automatic t_key_alternate();
        logic [31:0] s;
        do_reset();
        wr(8'h40, mk(7'h15, 1'b1, 8'h00));
        wr(8'h40, mk(7'h6A, 1'b1, 8'h00));
        wr(8'h40, mk(7'h6A, 1'b0, 8'h00));
        status(s);
        chk("R4 same key twice rejected", s, 32'h1);
        wr(8'h40, mk(7'h15, 1'b0, 8'h00));
        status(s);
        chk("R4 complement key accepted, stopped", s, 32'h0);
    endtask

    task automatic t_rescue();
        logic [31:0] s;
        do_reset();
        wr(8'h40, mk(7'h40, 1'b1, 8'h00));
        ticks(257);
        chk("R7 nmi raised", {31'h0, nmi_o}, 32'h1);
        wr(8'h40, mk(7'h3F, 1'b1, 8'h00));
        status(s);
        chk("R9 rescue clears nmi, running", s, 32'h1);
        ticks(256);
        chk("R5 reload from count field", {31'h0, nmi_o}, 32'h0);
        ticks(1);
        chk("R5 expiry after reload", {31'h0, nmi_o}, 32'h1);
    endtask

    task automatic t_address();
        logic [31:0] s;
        do_reset();
        wr(8'h44, mk(7'h15, 1'b1, 8'h00));
        wr(8'h48, mk(7'h15, 1'b1, 8'h00));
        status(s);
        chk("R2 writes off control offset ignored", s, 32'h0);
    endtask

    task automatic t_collision();
        do_reset();
        wr(8'h40, mk(7'h22, 1'b1, 8'h00), 1'b1);
        ticks(256);
        chk("R11 write wins over tick, no early nmi", {31'h0, nmi_o}, 32'h0);
        ticks(1);
        chk("R11 expiry after full count", {31'h0, nmi_o}, 32'h1);
    endtask

    initial begin
        t_reset();
        t_disabled();
        t_two_stage();
        t_bad_key();
        t_key_alternate();
        t_rescue();
        t_address();
        t_collision();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule